// File: doc/BRIEF.md
# Microwire Serial EEPROM Read Responder

This block is the serial half of a small three-wire EEPROM. The chip select, serial clock and data-in lines reach it as slow signals that it samples on a fast system clock. It finds their edges itself and collects one command per select cycle: a start bit, a two-bit opcode and a word address. For a read command it drives the addressed word back on the data-out line. A parallel load port fills the word store before or between serial transfers.

Three rules govern the protocol state. A rising edge on chip select restarts the command parser whatever the serial clock is doing. Any activity on the serial lines while select is low is ignored. The last sampled levels of select and clock survive a protocol restart, so the next clock edge after a restart is seen correctly. Opcodes other than read are parsed and then dropped. They leave the store and the output untouched.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released, `do_o` is 0. Reset is also honoured in the middle of a read.
- R2: Bits shifted in as 0 before the first 1 are skipped. The first 1 seen on an SK rise with CS high is the start bit.
- R3: After the start bit, the next two bits are the opcode, MSB first, and the next six bits are the word address, MSB first. Opcode 2'b10 is a read. After its last address bit, `do_o` carries a 0 up to and including the first SK fall. It then carries the 16 data bits, MSB first, with each later SK fall moving to the next bit.
- R4: Once the least significant data bit has been replaced on the next SK fall, `do_o` stays 0 until CS rises again.
- R5: `do_o` is 0 whenever CS is low, including in the middle of a read.
- R6: A CS rising edge discards any partly received command or read, whether SK is high or low at that moment.
- R7: SK and DI transitions while CS is low change nothing. `do_o` stays 0, and the next command after CS rises is parsed normally.
- R8: The last sampled SK level is not cleared by a protocol restart. If CS rises while SK is already high, that is not taken as an SK rising edge.
- R9: If CS and SK rise in the same sample, the restart is applied first. The SK rise is then taken as the first bit of the new command.
- R10: Opcodes 2'b00, 2'b01 and 2'b11 drive no data on `do_o` and leave the stored words unchanged.
- R11: A cycle with `ld_en_i` high writes `ld_data_i` into word `ld_addr_i`. A later read of that address returns the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four periods per SK half-period |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, asynchronous, active high |
| sk_i | input | 1 | Serial clock, asynchronous |
| di_i | input | 1 | Serial data in, asynchronous |
| do_o | output | 1 | Serial data out |
| ld_en_i | input | 1 | Parallel load strobe |
| ld_addr_i | input | 6 | Parallel load word address |
| ld_data_i | input | 16 | Parallel load word |

## Verification
Reads are run on data words with varied bit patterns: all ones, all zeros, a single bit set at each end, and mixed values. These patterns expose a wrong bit order, an off-by-one in the dummy-bit position, and a tail that does not fall back to 0. Some commands start with leading zeros, so start-bit detection is separated from fixed framing. Select is raised while SK is high, and in the same sample as an SK rise; each case leaves the next command aligned only if the restart and the retained edge history behave as required. Non-read opcodes are followed by a read of the same word, which shows that neither the output nor the store was disturbed.

// File: rtl/mw_pkg.sv
// Shared types for the three-wire EEPROM responder.
// Assumes: opcode is the two bits that follow the start bit, MSB first.
package mw_pkg;
    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } mw_op_e;
endpackage

// File: rtl/mw_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each input is held far longer than STAGES system clocks.
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mw_edge.sv
// Edge finder for chip select and serial clock.
// Assumes: inputs already synchronised. The previous-level flops follow
// the inputs on every cycle and are cleared only by the system reset.
module mw_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sk_s,
    output logic cs_prev,
    output logic sk_prev,
    output logic cs_rise,
    output logic sk_rise,
    output logic sk_fall
);
    // Remember last sampled levels; a protocol restart never touches these.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev <= 1'b0;
            sk_prev <= 1'b0;
        end else begin
            cs_prev <= cs_s;
            sk_prev <= sk_s;
        end
    end

    // Derive single-cycle edge strobes.
    always_comb begin
        cs_rise = cs_s & ~cs_prev;
        sk_rise = sk_s & ~sk_prev;
        sk_fall = ~sk_s & sk_prev;
    end
endmodule

// File: rtl/mw_store.sv
// Word store with a parallel write port and an asynchronous read port.
// Assumes: contents are not reset; they are filled through the load port.
module mw_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write a word from the load port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mw_proto.sv
// Command parser and read shifter.
// Assumes: edge strobes last one cycle. Only a read has an effect;
// other opcodes are parsed and dropped.
module mw_proto
    import mw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              di_s,
    input  logic              cs_rise,
    input  logic              sk_rise,
    input  logic              sk_fall,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              reading,
    output logic [$clog2(ADDR_W+4)-1:0] in_cnt,
    output logic [$clog2(DATA_W+3)-1:0] out_cnt,
    output logic              do_o
);
    localparam int CMD_W  = ADDR_W + 2;
    localparam int CNT_W  = $clog2(ADDR_W + 4);
    localparam int OCNT_W = $clog2(DATA_W + 3);
    localparam logic [CNT_W-1:0]  DONE     = CNT_W'(CMD_W + 1);
    localparam logic [OCNT_W-1:0] OUT_LAST = OCNT_W'(DATA_W + 2);
    localparam logic [OCNT_W-1:0] FIRST_D  = OCNT_W'(2);
    localparam logic [OCNT_W-1:0] LAST_D   = OCNT_W'(DATA_W + 1);

    logic [CMD_W-1:0]  in_sr, n_sr;
    logic [CNT_W-1:0]  n_cnt;
    logic [OCNT_W-1:0] n_ocnt;
    logic              n_rd;
    logic [ADDR_W-1:0] n_addr;
    logic [OCNT_W-1:0] sel;
    logic [DATA_W-1:0] mask;

    // Next-state: restart on CS rise first, then the SK edges, all gated by CS.
    always_comb begin
        n_sr   = in_sr;
        n_cnt  = in_cnt;
        n_ocnt = out_cnt;
        n_rd   = reading;
        n_addr = rd_addr;
        if (cs_s) begin
            if (cs_rise) begin
                n_sr   = '0;
                n_cnt  = '0;
                n_ocnt = '0;
                n_rd   = 1'b0;
            end
            if (sk_rise) begin
                if (n_cnt == '0) begin
                    if (di_s) n_cnt = CNT_W'(1);
                end else if (n_cnt != DONE) begin
                    n_sr  = {n_sr[CMD_W-2:0], di_s};
                    n_cnt = n_cnt + CNT_W'(1);
                    if (n_cnt == DONE &&
                        mw_op_e'(n_sr[CMD_W-1 -: 2]) == OP_READ) begin
                        n_rd   = 1'b1;
                        n_addr = n_sr[ADDR_W-1:0];
                        n_ocnt = '0;
                    end
                end
            end
            if (sk_fall && n_ocnt != OUT_LAST) n_ocnt = n_ocnt + OCNT_W'(1);
        end
    end

    // Register the protocol state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_sr   <= '0;
            in_cnt  <= '0;
            out_cnt <= '0;
            reading <= 1'b0;
            rd_addr <= '0;
        end else begin
            in_sr   <= n_sr;
            in_cnt  <= n_cnt;
            out_cnt <= n_ocnt;
            reading <= n_rd;
            rd_addr <= n_addr;
        end
    end

    // Pick the current data bit, MSB first, after the dummy slot.
    always_comb begin
        sel  = LAST_D - out_cnt;
        mask = DATA_W'(1) << sel;
        do_o = cs_s & reading & (out_cnt >= FIRST_D) & (out_cnt <= LAST_D)
             & (|(rd_data & mask));
    end
endmodule

// File: rtl/mw_eeprom_slave.sv
// Top of the three-wire EEPROM responder: synchroniser, edge finder,
// command parser and word store.
// Assumes: SK half-period spans at least four system clocks.
module mw_eeprom_slave #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    output logic              do_o,
    input  logic              ld_en_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [DATA_W-1:0] ld_data_i
);
    logic [2:0]        syn;
    logic              cs_s, sk_s, di_s;
    logic              cs_prev, sk_prev, cs_rise, sk_rise, sk_fall;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              reading;
    logic [$clog2(ADDR_W+4)-1:0] in_cnt;
    logic [$clog2(DATA_W+3)-1:0] out_cnt;

    mw_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i({cs_i, sk_i, di_i}), .q_o(syn)
    );
    assign {cs_s, sk_s, di_s} = syn;

    mw_edge u_edge (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_s(sk_s),
        .cs_prev(cs_prev), .sk_prev(sk_prev),
        .cs_rise(cs_rise), .sk_rise(sk_rise), .sk_fall(sk_fall)
    );

    mw_proto #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_proto (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .di_s(di_s),
        .cs_rise(cs_rise), .sk_rise(sk_rise), .sk_fall(sk_fall),
        .rd_data(rd_data), .rd_addr(rd_addr), .reading(reading),
        .in_cnt(in_cnt), .out_cnt(out_cnt), .do_o(do_o)
    );

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .wr_en(ld_en_i), .wr_addr(ld_addr_i), .wr_data(ld_data_i),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/mw_eeprom_chk.sv
// Protocol checker for the EEPROM responder, bound into the top.
// Assumes: names match the top's internal nets.
module mw_eeprom_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sk_s,
    input logic cs_prev,
    input logic sk_prev,
    input logic cs_rise,
    input logic reading,
    input logic [$clog2(ADDR_W+4)-1:0] in_cnt,
    input logic [$clog2(DATA_W+3)-1:0] out_cnt,
    input logic do_o
);
    localparam int CNT_W  = $clog2(ADDR_W + 4);
    localparam int OCNT_W = $clog2(DATA_W + 3);
    localparam logic [CNT_W-1:0]  DONE     = CNT_W'(ADDR_W + 3);
    localparam logic [OCNT_W-1:0] OUT_LAST = OCNT_W'(DATA_W + 2);

    // Output silent while deselected (R5).
    p_do_low_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |-> !do_o);

    // A select rise leaves no read in progress (R6).
    p_cs_rise_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !reading);

    // Deselected cycles leave parser state alone (R7).
    p_idle_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> ($stable(in_cnt) && $stable(out_cnt) && $stable(reading)));

    // Previous-level flops track the synchronised lines (R8).
    p_prev_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sk_prev == $past(sk_s)) && (cs_prev == $past(cs_s)));

    // Tail of a read is quiet (R4).
    p_tail_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cnt == OUT_LAST) |-> !do_o);

    // A read starts only once the whole command is in (R3).
    p_read_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reading) |-> (in_cnt == DONE));
endmodule

bind mw_eeprom_slave mw_eeprom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sk_s(sk_s),
    .cs_prev(cs_prev), .sk_prev(sk_prev), .cs_rise(cs_rise),
    .reading(reading), .in_cnt(in_cnt), .out_cnt(out_cnt), .do_o(do_o)
);

// File: tb/sim_mw_eeprom_slave.sv
module sim_mw_eeprom_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NVEC       = 6;
    // {leading zeros[1:0], address[5:0], data[15:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {2'd0, 6'h00, 16'hA5C3},
        {2'd1, 6'h3F, 16'hFFFF},
        {2'd2, 6'h15, 16'h8001},
        {2'd3, 6'h2A, 16'h1234},
        {2'd0, 6'h07, 16'h0000},
        {2'd1, 6'h30, 16'h7FFE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_i = 1'b0, sk_i = 1'b0, di_i = 1'b0;
    logic do_o;
    logic ld_en_i = 1'b0;
    logic [5:0]  ld_addr_i = '0;
    logic [15:0] ld_data_i = '0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mw_eeprom_slave u0 (
        .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
        .do_o(do_o), .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i),
        .ld_data_i(ld_data_i)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: do_o actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic load(logic [5:0] a, logic [15:0] d);
        ld_en_i = 1'b1; ld_addr_i = a; ld_data_i = d;
        tick(1);
        ld_en_i = 1'b0;
    endtask

    task automatic clk_bit(logic b);
        di_i = b; sk_i = 1'b0; tick(HALF);
        sk_i = 1'b1; tick(HALF);
    endtask

    task automatic begin_cs();
        sk_i = 1'b0; di_i = 1'b0; cs_i = 1'b1; tick(HALF);
    endtask

    task automatic end_cs();
        cs_i = 1'b0; sk_i = 1'b0; tick(HALF);
    endtask

    task automatic send_cmd(int zeros, logic [1:0] op, logic [5:0] a);
        for (int i = 0; i < zeros; i++) clk_bit(1'b0);
        clk_bit(1'b1);
        clk_bit(op[1]);
        clk_bit(op[0]);
        for (int i = 5; i >= 0; i--) clk_bit(a[i]);
    endtask

    // Fall 0: dummy; falls 1..16: D15..D0; later falls: quiet tail.
    task automatic collect(logic [15:0] exp, string tag);
        for (int f = 0; f < 20; f++) begin
            sk_i = 1'b0; tick(HALF);
            if (f == 0)       chk({tag, " R3 dummy"}, do_o, 1'b0);
            else if (f <= 16) chk(tag, do_o, exp[16-f]);
            else              chk("R4 tail", do_o, 1'b0);
            sk_i = 1'b1; tick(HALF);
        end
    endtask

    initial begin
        logic bad;
        // R1: reset state
        tick(3);
        chk("R1 in reset", do_o, 1'b0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after reset", do_o, 1'b0);

        // R11 preload through the load port, then the vector walk (R2, R3, R4)
        for (int v = 0; v < NVEC; v++) load(VEC[v][21:16], VEC[v][15:0]);
        for (int v = 0; v < NVEC; v++) begin
            begin_cs();
            send_cmd(int'(VEC[v][23:22]), 2'b10, VEC[v][21:16]);
            collect(VEC[v][15:0], (VEC[v][23:22] != 0) ? "R2 R3" : "R3");
            end_cs();
        end

        // R2: long run of leading zeros
        begin_cs(); send_cmd(6, 2'b10, 6'h2A); collect(16'h1234, "R2"); end_cs();

        // R5 and R7: drop CS mid-read, toggle SK/DI while deselected
        begin_cs(); send_cmd(0, 2'b10, 6'h3F);
        sk_i = 1'b0; tick(HALF); sk_i = 1'b1; tick(HALF);
        sk_i = 1'b0; tick(HALF);
        chk("R5 pre D15", do_o, 1'b1);
        cs_i = 1'b0; tick(HALF);
        chk("R5 cs low", do_o, 1'b0);
        for (int i = 0; i < 6; i++) begin
            di_i = i[0]; sk_i = ~sk_i; tick(HALF);
            chk("R7 cs low sk toggle", do_o, 1'b0);
        end
        begin_cs(); send_cmd(0, 2'b10, 6'h15); collect(16'h8001, "R7"); end_cs();

        // R6: abandon a partial command; CS falls and rises while SK high
        begin_cs(); clk_bit(1'b1); clk_bit(1'b1);
        cs_i = 1'b0; tick(HALF);
        cs_i = 1'b1; tick(HALF);
        send_cmd(0, 2'b10, 6'h2A); collect(16'h1234, "R6"); end_cs();

        // R8: CS rises while SK already high with DI=1; no false SK edge
        sk_i = 1'b1; di_i = 1'b1; tick(HALF);
        cs_i = 1'b1; tick(HALF);
        send_cmd(1, 2'b10, 6'h00); collect(16'hA5C3, "R8"); end_cs();

        // R9: CS and SK rise together; that rise is the start bit
        di_i = 1'b1; cs_i = 1'b1; sk_i = 1'b1; tick(HALF);
        clk_bit(1'b1); clk_bit(1'b0);
        for (int i = 5; i >= 0; i--) clk_bit(6'h30 >> i);
        collect(16'h7FFE, "R9"); end_cs();

        // R10: non-read opcodes produce nothing and keep the store
        for (int k = 0; k < 3; k++) begin
            logic [1:0] op;
            op = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
            begin_cs(); send_cmd(0, op, 6'h00);
            bad = 1'b0;
            for (int f = 0; f < 20; f++) begin
                di_i = 1'b1; sk_i = 1'b0; tick(HALF);
                bad |= do_o;
                sk_i = 1'b1; tick(HALF);
            end
            chk("R10 no output", bad, 1'b0);
            end_cs();
        end
        begin_cs(); send_cmd(0, 2'b10, 6'h00); collect(16'hA5C3, "R10 store"); end_cs();

        // R11: overwrite a word and read it back
        load(6'h15, 16'h5AA5);
        begin_cs(); send_cmd(0, 2'b10, 6'h15); collect(16'h5AA5, "R11"); end_cs();

        // R1: reset in the middle of a read
        begin_cs(); send_cmd(0, 2'b10, 6'h3F);
        sk_i = 1'b0; tick(HALF); sk_i = 1'b1; tick(HALF);
        sk_i = 1'b0; tick(HALF);
        chk("R1 pre reset D15", do_o, 1'b1);
        rst_n = 1'b0; tick(2);
        chk("R1 mid-read reset", do_o, 1'b0);
        rst_n = 1'b1; tick(HALF);
        chk("R1 after mid-read reset", do_o, 1'b0);
        end_cs();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..R11 run: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule